// File: doc/BRIEF.md
# Voice Sample Serial Port with Receive Gain

This block is the digital half of a voice-band codec's serial sample port. Every frame-sync pulse starts one exchange: a parallel transmit word is loaded and shifted out MSB first on a single output line, while a receive word is assembled MSB first from a single input line. Both directions run at the rate of the master bit clock. A static mode input selects the width of the exchange. Linear mode uses 16-bit words. µ-law mode uses 8-bit companded codes.

In linear mode the received word carries two fields. The upper 13 bits hold a signed audio sample and the lower 3 bits hold a per-sample volume code. The port scales the sample by the gain that the code selects, which runs from -18 dB to +3 dB in 3 dB steps, and saturates the result to the 13-bit signed range. In µ-law mode the received code is passed through unscaled. A one-cycle strobe marks each transmit-word load, and another marks each completed receive sample. The host can use these strobes to track frame alignment.

Top module: `voice_pcm_port`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `txLoad`, `rxValid` and `serialOut` are 0 and `rxData` is 0.
- R2: `frameSync` is sampled on rising clock edges. `txLoad` is 1 for exactly the one cycle that follows an edge at which `frameSync` was 1.
- R3: In linear mode (`linearMode`=1), `serialOut` carries `txWord[15-i]` during the i-th cycle after the sync edge, for i = 0..15.
- R4: In linear mode, `serialIn` is captured at the 1st through 16th rising edges after the sync edge, MSB first. `rxValid` is 1 for one cycle, in the cycle after the 16th capture.
- R5: In a received linear word, bits 15:3 are the two's-complement sample and bits 2:0 are the volume code.
- R6: The volume code selects a gain in units of 1/256: code 0 to 7 map to 32, 46, 64, 91, 128, 181, 256 and 362, which correspond to -18 dB through +3 dB. Code 6 is unity. `rxData` = floor(sample × gain / 256).
- R7: A scaled linear result above 4095 outputs 4095, and a result below -4096 outputs -4096.
- R8: In µ-law mode (`linearMode`=0), `serialOut` carries `txWord[7-i]` during cycles i = 0..7 after the sync edge. `serialOut` is 0 in every cycle outside a frame's active bit periods.
- R9: In µ-law mode, 8 bits are captured and `rxValid` pulses in the cycle after the 8th capture. `rxData` = {5'b0, code}, with no volume scaling. Input bits after the 8th capture neither change `rxData` nor raise `rxValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| linearMode | input | 1 | 1 = 16-bit linear words, 0 = 8-bit µ-law codes |
| frameSync | input | 1 | Frame start, sampled on rising edges |
| txWord | input | 16 | Parallel transmit word, loaded at the sync edge |
| serialIn | input | 1 | Serial receive data |
| serialOut | output | 1 | Serial transmit data |
| txLoad | output | 1 | One-cycle strobe after each transmit-word load |
| rxData | output | 13 | Received sample: scaled linear value or zero-extended µ-law code |
| rxValid | output | 1 | One-cycle strobe for a completed receive sample |

## Verification
Let the sync edge be edge k. `txLoad` is due in the cycle after edge k. Transmit bit i is due in the cycle after edge k+i. The receive result and `rxValid` are due in the cycle after edge k+16 in linear mode, or after edge k+8 in µ-law mode. The bench drives inputs and samples outputs only on falling edges. It walks the frame one falling edge at a time, so each check lands exactly in the cycle its result is due. After each frame, idle cycles with random input confirm that the line stays low and that no stray strobe appears.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  typedef struct packed {
    logic load;
    logic shift;
    logic finish;
    logic drive;
  } ctrlStrobes_t;
endpackage

// File: rtl/pcm_port_ctrl.sv
module pcm_port_ctrl
  import pcm_port_pkg::*;
#(
  parameter int WORD_BITS = 16,
  parameter int LAW_BITS  = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         linearMode,
  input  logic         frameSync,
  output ctrlStrobes_t strobes
);
  localparam int CNT_W = $clog2(WORD_BITS);
  localparam logic [CNT_W-1:0] LIN_LAST = CNT_W'(WORD_BITS - 1);
  localparam logic [CNT_W-1:0] LAW_LAST = CNT_W'(LAW_BITS - 1);

  logic             active;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] lastIdx;

  assign lastIdx = linearMode ? LIN_LAST : LAW_LAST;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      bitCnt <= '0;
    end else if (frameSync) begin
      active <= 1'b1;
      bitCnt <= '0;
    end else if (active) begin
      bitCnt <= bitCnt + 1'b1;
      if (bitCnt == lastIdx) active <= 1'b0;
    end
  end

  always_comb begin
    strobes.load   = frameSync;
    strobes.shift  = active;
    strobes.finish = active && (bitCnt == lastIdx);
    strobes.drive  = active;
  end

  // R3: within a frame the bit counter advances by one per edge until the frame closes
  assert_count_advance_R3: assert property (@(posedge clk) disable iff (!rstN)
    (active && !frameSync && bitCnt != lastIdx) |=> (bitCnt == $past(bitCnt) + 1'b1));
endmodule

// File: rtl/pcm_port_datapath.sv
module pcm_port_datapath
  import pcm_port_pkg::*;
#(
  parameter int WORD_BITS   = 16,
  parameter int SAMPLE_BITS = 13,
  parameter int LAW_BITS    = 8,
  parameter int GAIN_FRAC   = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   linearMode,
  input  ctrlStrobes_t           strobes,
  input  logic [WORD_BITS-1:0]   txWord,
  input  logic                   serialIn,
  output logic                   serialOut,
  output logic                   txLoad,
  output logic [SAMPLE_BITS-1:0] rxData,
  output logic                   rxValid
);
  localparam int VOL_BITS  = WORD_BITS - SAMPLE_BITS;
  localparam int GAIN_W    = GAIN_FRAC + 2;
  localparam int PROD_W    = SAMPLE_BITS + GAIN_W + 1;
  localparam logic signed [PROD_W-1:0] SAT_HI = PROD_W'((1 <<< (SAMPLE_BITS - 1)) - 1);
  localparam logic signed [PROD_W-1:0] SAT_LO = -PROD_W'(1 <<< (SAMPLE_BITS - 1));

  logic [WORD_BITS-1:0]          txShift;
  logic [WORD_BITS-1:0]          rxShift;
  logic [WORD_BITS-1:0]          fullWord;
  logic signed [SAMPLE_BITS-1:0] sampleIn;
  logic [VOL_BITS-1:0]           volCode;
  logic [GAIN_W-1:0]             gain;
  logic signed [PROD_W-1:0]      product;
  logic signed [PROD_W-1:0]      scaled;
  logic [SAMPLE_BITS-1:0]        linResult;
  logic [SAMPLE_BITS-1:0]        lawResult;

  assign fullWord = {rxShift[WORD_BITS-2:0], serialIn};
  assign sampleIn = fullWord[WORD_BITS-1:VOL_BITS];
  assign volCode  = fullWord[VOL_BITS-1:0];

  // gains in units of 2^-GAIN_FRAC, about 10^(dB/20) for -18..+3 dB
  always_comb begin
    case (volCode)
      3'd0:    gain = GAIN_W'(32);
      3'd1:    gain = GAIN_W'(46);
      3'd2:    gain = GAIN_W'(64);
      3'd3:    gain = GAIN_W'(91);
      3'd4:    gain = GAIN_W'(128);
      3'd5:    gain = GAIN_W'(181);
      3'd6:    gain = GAIN_W'(256);
      default: gain = GAIN_W'(362);
    endcase
  end

  assign product = PROD_W'(sampleIn) * $signed({1'b0, gain});
  assign scaled  = product >>> GAIN_FRAC;

  always_comb begin
    if (scaled > SAT_HI)      linResult = SAT_HI[SAMPLE_BITS-1:0];
    else if (scaled < SAT_LO) linResult = SAT_LO[SAMPLE_BITS-1:0];
    else                      linResult = scaled[SAMPLE_BITS-1:0];
  end

  assign lawResult = SAMPLE_BITS'(fullWord[LAW_BITS-1:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxData  <= '0;
      rxValid <= 1'b0;
      txLoad  <= 1'b0;
    end else begin
      txLoad  <= strobes.load;
      rxValid <= strobes.finish;
      if (strobes.load)
        txShift <= linearMode ? txWord
                              : {txWord[LAW_BITS-1:0], {(WORD_BITS-LAW_BITS){1'b0}}};
      else if (strobes.shift)
        txShift <= {txShift[WORD_BITS-2:0], 1'b0};
      if (strobes.shift) rxShift <= fullWord;
      if (strobes.finish) rxData <= linearMode ? linResult : lawResult;
    end
  end

  assign serialOut = strobes.drive & txShift[WORD_BITS-1];

  // R6: unity code reproduces the received sample
  assert_unity_gain_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.finish && linearMode && volCode == 3'd6) |=> (rxData == $past(sampleIn)));
  // R7: boost never shrinks a positive sample
  assert_boost_monotonic_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.finish && linearMode && volCode == 3'd7 && sampleIn > 0)
      |=> ($signed(rxData) >= $past(sampleIn)));
  // R9: companded codes come out zero-extended
  assert_law_zero_ext_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !linearMode) |-> (rxData[SAMPLE_BITS-1:LAW_BITS] == '0));
endmodule

// File: rtl/voice_pcm_port.sv
module voice_pcm_port
  import pcm_port_pkg::*;
#(
  parameter int WORD_BITS   = 16,
  parameter int SAMPLE_BITS = 13,
  parameter int LAW_BITS    = 8,
  parameter int GAIN_FRAC   = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   linearMode,
  input  logic                   frameSync,
  input  logic [WORD_BITS-1:0]   txWord,
  input  logic                   serialIn,
  output logic                   serialOut,
  output logic                   txLoad,
  output logic [SAMPLE_BITS-1:0] rxData,
  output logic                   rxValid
);
  ctrlStrobes_t strobes;

  pcm_port_ctrl #(.WORD_BITS(WORD_BITS), .LAW_BITS(LAW_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .linearMode(linearMode),
    .frameSync(frameSync), .strobes(strobes)
  );

  pcm_port_datapath #(
    .WORD_BITS(WORD_BITS), .SAMPLE_BITS(SAMPLE_BITS),
    .LAW_BITS(LAW_BITS), .GAIN_FRAC(GAIN_FRAC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .linearMode(linearMode), .strobes(strobes),
    .txWord(txWord), .serialIn(serialIn), .serialOut(serialOut),
    .txLoad(txLoad), .rxData(rxData), .rxValid(rxValid)
  );

  // R2: a sampled sync is always followed by a load strobe
  assert_load_after_sync_R2: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |=> txLoad);
endmodule

// File: tb/tb_voice_pcm_port.sv
module tb_voice_pcm_port;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        linearMode = 1'b1;
  logic        frameSync = 1'b0;
  logic [15:0] txWord = '0;
  logic        serialIn = 1'b0;
  logic        serialOut;
  logic        txLoad;
  logic [12:0] rxData;
  logic        rxValid;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  voice_pcm_port dut (
    .clk(clk), .rstN(rstN), .linearMode(linearMode), .frameSync(frameSync),
    .txWord(txWord), .serialIn(serialIn), .serialOut(serialOut),
    .txLoad(txLoad), .rxData(rxData), .rxValid(rxValid)
  );

  task automatic check(input string req, input int actual, input int expected);
    testsRun++;
    if (actual != expected) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  function automatic int gainOf(input int code);
    case (code)
      0: return 32;  1: return 46;  2: return 64;  3: return 91;
      4: return 128; 5: return 181; 6: return 256; default: return 362;
    endcase
  endfunction

  // R5 R6 R7: expected scaled sample from a received linear word
  function automatic int expectLinear(input logic [15:0] w);
    int s, p, q;
    s = int'($signed(w[15:3]));
    p = s * gainOf(int'(w[2:0]));
    q = p >>> 8;
    if (q > 4095) q = 4095;
    if (q < -4096) q = -4096;
    return q & 32'h1FFF;
  endfunction

  task automatic runFrame(input bit lin, input logic [15:0] tx, input logic [15:0] rx);
    int n = lin ? 16 : 8;
    logic [12:0] held;
    linearMode = lin;
    txWord = tx;
    frameSync = 1'b1;
    @(negedge clk);
    frameSync = 1'b0;
    txWord = 16'($urandom);
    check("R2 txLoad", int'(txLoad), 1);
    for (int i = 0; i < n; i++) begin
      serialIn = lin ? rx[15-i] : rx[7-i];
      if (lin) check("R3 serialOut bit", int'(serialOut), int'(tx[15-i]));
      else     check("R8 serialOut bit", int'(serialOut), int'(tx[7-i]));
      if (i > 0) check("R2 txLoad one cycle", int'(txLoad), 0);
      @(negedge clk);
    end
    if (lin) begin
      check("R4 rxValid", int'(rxValid), 1);
      check("R6/R7 rxData", int'(rxData), expectLinear(rx));
    end else begin
      check("R9 rxValid", int'(rxValid), 1);
      check("R9 rxData", int'(rxData), int'(rx[7:0]));
    end
    held = rxData;
    for (int j = 0; j < 10; j++) begin
      serialIn = 1'($urandom);
      @(negedge clk);
      check("R8 idle serialOut", int'(serialOut), 0);
      check("R9 no stray rxValid", int'(rxValid), 0);
      check("R9 rxData held", int'(rxData), int'(held));
    end
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    check("R1 reset txLoad", int'(txLoad), 0);
    check("R1 reset rxValid", int'(rxValid), 0);
    check("R1 reset serialOut", int'(serialOut), 0);
    check("R1 reset rxData", int'(rxData), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 post-reset rxValid", int'(rxValid), 0);
    check("R1 post-reset rxData", int'(rxData), 0);
    // directed corner cases
    runFrame(1'b1, 16'hA5C3, {13'sd4095, 3'd7});   // R7 positive saturation
    runFrame(1'b1, 16'h0001, {-13'sd4096, 3'd7});  // R7 negative saturation
    runFrame(1'b1, 16'h8000, {-13'sd1234, 3'd6});  // R6 unity
    runFrame(1'b1, 16'hFFFF, {-13'sd1, 3'd0});     // R6 floor on negative
    runFrame(1'b1, 16'h1234, {13'sd1000, 3'd4});   // R5 field split
    runFrame(1'b0, 16'hFF81, 16'hFFE7);            // R8 R9 mu-law
    runFrame(1'b0, 16'h0000, 16'h0080);
    // constrained random
    for (int k = 0; k < 40; k++)
      runFrame(1'($urandom), 16'($urandom), 16'($urandom));
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule